// File: doc/BRIEF.md
# Flash Burst Read Buffer Controller

This block sits between an on-chip read bus and a slow non-volatile memory array. Reads are served from two tagged line buffers of 32 bytes each. The first beat of every read takes two clocks. When the bus asks for a burst, each further beat takes one clock. A burst walks upward one 32-bit word per beat and stops at the last word of its line, or earlier if the bus withdraws the burst.

Each accepted read compares the line part of its address against the tags of both buffers. On a hit the array is left idle, which saves power. On a miss the whole line is fetched through a synchronous line-read port with one clock of latency. The line goes into the buffer that was used less recently. The first word is forwarded straight from the array data.

An invalidate input drops both buffers whenever the array contents change. Some requests get no response and leave the buffers untouched: writes, addresses outside the configured region, and user-space accesses when these are not allowed.

Top module: `flash_burst_buf`

## Requirements
- R1: When a request is accepted at rising edge t while the block is idle, `rsp_ready` is low in the cycle after edge t and high in the cycle after edge t+1. That cycle carries the first beat.
- R2: If `req_valid` and `req_burst` are both high during a beat cycle and the word index is below 7, the next cycle is also a beat. It carries the word at the next higher word index of the same line.
- R3: If `req_valid` or `req_burst` is low during a beat cycle, `rsp_ready` is low in the next cycle and the block is idle again.
- R4: The word index is address bits [4:2]. The beat at word index 7 is always the last beat of a burst, and the index never wraps to 0.
- R5: Address bits [1:0] are ignored. `rsp_data` is the full 32-bit word selected by bits [23:2].
- R6: A request whose line address (bits [23:5]) matches a valid buffer tag keeps `arr_rd` low.
- R7: On a miss, `arr_rd` is high in the request cycle and `arr_addr` equals the line address. The line is stored in the least-recently-used buffer, and its tag and valid bit are set. After reset buffer 0 counts as least recently used. Each hit or fill makes the other buffer the least recently used.
- R8: `invalidate` high at an edge clears both valid bits, so lookups from the next cycle on miss. It wins over a fill at the same edge.
- R9: A request with `req_write` high gets no `rsp_ready`, issues no array read and leaves tags, valid bits and replacement order unchanged.
- R10: A request with bits [23:18] differing from the region base (default 6'h01), or with `req_user` high while user access is disallowed (the default), is handled exactly like R9.
- R11: After reset `rsp_ready` is low and both buffers are invalid.
- R12: While a transfer is in progress, `req_addr` is ignored and `arr_rd` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 24 | Byte address |
| req_write | input | 1 | Request is a write |
| req_user | input | 1 | Request comes from user space |
| req_burst | input | 1 | Bus wants another beat after the current one |
| invalidate | input | 1 | Array contents changed; drop both buffers |
| rsp_ready | output | 1 | Beat completes this cycle |
| rsp_data | output | 32 | Beat data |
| arr_rd | output | 1 | Array line read strobe |
| arr_addr | output | 19 | Array line address |
| arr_rdata | input | 256 | Line from the array, one clock after `arr_rd` |

## Verification
Single-word reads are issued at several offsets and with junk in the byte bits. These separate the two-clock first access and the word selection from any burst effect. Bursts are started mid-line with a short requested length, and also near the line end with an over-long length. This tells the stop requested by the bus apart from the stop at the line boundary. A three-line access sequence forces an eviction and shows whether the least-recently-used buffer is the one replaced. Writes, out-of-region addresses, user accesses and an invalidate pulse timed on the fill edge are each followed by a read of a buffered line, so the array strobe shows whether buffer state was disturbed.

// File: rtl/flash_bb_pkg.sv
package flash_bb_pkg;
  localparam int NUM_BUFS = 2;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_BEAT = 2'd2
  } fbb_state_e;
endpackage

// File: rtl/fbb_tag_match.sv
module fbb_tag_match
  import flash_bb_pkg::*;
#(
  parameter int TAG_W = 19
) (
  input  logic [TAG_W-1:0]                look_tag,
  input  logic [NUM_BUFS-1:0][TAG_W-1:0]  tags,
  input  logic [NUM_BUFS-1:0]             valid,
  output logic                            hit,
  output logic                            hit_way
);
  logic [NUM_BUFS-1:0] way_hit;

  genvar w;
  generate
    for (w = 0; w < NUM_BUFS; w++) begin : g_cmp
      assign way_hit[w] = valid[w] && (tags[w] == look_tag);
    end
  endgenerate

  assign hit     = |way_hit;
  assign hit_way = way_hit[1];
endmodule

// File: rtl/fbb_line_store.sv
module fbb_line_store
  import flash_bb_pkg::*;
#(
  parameter int DW   = 32,
  parameter int WPL  = 8,
  parameter int OFFW = 3
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_way,
  input  logic [WPL*DW-1:0] wr_line,
  input  logic              rd_way,
  input  logic [OFFW-1:0]   rd_off,
  output logic [DW-1:0]     rd_word
);
  localparam int DEPTH = NUM_BUFS * WPL;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int w = 0; w < WPL; w++) begin
        mem[{wr_way, OFFW'(w)}] <= wr_line[w*DW +: DW];
      end
    end
  end

  assign rd_word = mem[{rd_way, rd_off}];
endmodule

// File: rtl/flash_burst_buf.sv
module flash_burst_buf
  import flash_bb_pkg::*;
#(
  parameter int             AW          = 24,
  parameter int             DW          = 32,
  parameter int             LINE_BYTES  = 32,
  parameter logic [AW-1:0]  BASE_ADDR   = 24'h040000,
  parameter int             REGION_BITS = 18,
  parameter bit             ALLOW_USER  = 1'b0,
  localparam int            LINE_LSB    = $clog2(LINE_BYTES),
  localparam int            TAG_W       = AW - LINE_LSB,
  localparam int            LINE_W      = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_write,
  input  logic              req_user,
  input  logic              req_burst,
  input  logic              invalidate,
  output logic              rsp_ready,
  output logic [DW-1:0]     rsp_data,
  output logic              arr_rd,
  output logic [TAG_W-1:0]  arr_addr,
  input  logic [LINE_W-1:0] arr_rdata
);
  localparam int BYTE_W = $clog2(DW / 8);
  localparam int WPL    = LINE_BYTES / (DW / 8);
  localparam int OFFW   = $clog2(WPL);

  fbb_state_e                      state;
  logic [NUM_BUFS-1:0][TAG_W-1:0]  tags;
  logic [NUM_BUFS-1:0]             valid;
  logic                            lru;
  logic                            cur_way;
  logic [OFFW-1:0]                 cur_off;
  logic                            miss_pend;
  logic [TAG_W-1:0]                cap_tag;
  logic                            rsp_ready_q;
  logic [DW-1:0]                   rsp_data_q;

  logic [TAG_W-1:0] look_tag;
  logic             in_region, space_ok, accept;
  logic             hit, hit_way, fill;
  logic [OFFW-1:0]  rd_off;
  logic [DW-1:0]    store_word, first_word;
  logic             unused_bits;

  assign unused_bits = ^req_addr[BYTE_W-1:0];

  assign look_tag  = req_addr[AW-1:LINE_LSB];
  assign in_region = req_addr[AW-1:REGION_BITS] == BASE_ADDR[AW-1:REGION_BITS];
  assign space_ok  = ALLOW_USER || !req_user;
  assign accept    = (state == ST_IDLE) && req_valid && !req_write &&
                     in_region && space_ok;

  fbb_tag_match #(.TAG_W(TAG_W)) u_match (
    .look_tag (look_tag),
    .tags     (tags),
    .valid    (valid),
    .hit      (hit),
    .hit_way  (hit_way)
  );

  assign arr_rd   = accept && !hit;
  assign arr_addr = look_tag;

  assign fill   = (state == ST_WAIT) && miss_pend;
  assign rd_off = (state == ST_BEAT) ? cur_off + 1'b1 : cur_off;

  fbb_line_store #(.DW(DW), .WPL(WPL), .OFFW(OFFW)) u_store (
    .clk     (clk),
    .wr_en   (fill),
    .wr_way  (cur_way),
    .wr_line (arr_rdata),
    .rd_way  (cur_way),
    .rd_off  (rd_off),
    .rd_word (store_word)
  );

  assign first_word = miss_pend ? arr_rdata[cur_off*DW +: DW] : store_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      tags        <= '0;
      lru         <= 1'b0;
      cur_way     <= 1'b0;
      cur_off     <= '0;
      miss_pend   <= 1'b0;
      cap_tag     <= '0;
      rsp_ready_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state     <= ST_WAIT;
            cur_off   <= req_addr[LINE_LSB-1:BYTE_W];
            cap_tag   <= look_tag;
            miss_pend <= !hit;
            if (hit) begin
              cur_way <= hit_way;
              lru     <= !hit_way;
            end else begin
              cur_way <= lru;
            end
          end
        end
        ST_WAIT: begin
          rsp_ready_q <= 1'b1;
          rsp_data_q  <= first_word;
          state       <= ST_BEAT;
          if (miss_pend) begin
            tags[cur_way] <= cap_tag;
            lru           <= !cur_way;
          end
        end
        ST_BEAT: begin
          if (req_valid && req_burst && (cur_off != '1)) begin
            cur_off    <= cur_off + 1'b1;
            rsp_data_q <= store_word;
          end else begin
            rsp_ready_q <= 1'b0;
            state       <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || invalidate) begin
      valid <= '0;
    end else if (fill) begin
      valid[cur_way] <= 1'b1;
    end
  end

  assign rsp_ready = rsp_ready_q;
  assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/flash_burst_buf_chk.sv
module flash_burst_buf_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_burst,
  input logic       invalidate,
  input logic       rsp_ready,
  input logic       arr_rd,
  input logic       at_last,
  input logic [1:0] valid
);
  // R1
  first_beat_delay_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_ready) |-> $past(req_valid, 2));

  // R2
  burst_continue_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_ready && req_valid && req_burst && !at_last |=> rsp_ready);

  // R3
  burst_stop_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_ready && !(req_valid && req_burst) |=> !rsp_ready);

  // R4
  line_end_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_ready && at_last |=> !rsp_ready);

  // R7
  miss_latency_chk: assert property (@(posedge clk) disable iff (rst)
    arr_rd |-> ##2 rsp_ready);

  // R8
  inval_clear_chk: assert property (@(posedge clk) disable iff (rst)
    invalidate |=> valid == 2'b00);

  // R12
  busy_no_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_ready |-> !arr_rd);
endmodule

bind flash_burst_buf flash_burst_buf_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_burst  (req_burst),
  .invalidate (invalidate),
  .rsp_ready  (rsp_ready),
  .arr_rd     (arr_rd),
  .at_last    (&cur_off),
  .valid      (valid)
);

// File: tb/flash_burst_buf_test.sv
module flash_burst_buf_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic [23:0]  req_addr = '0;
  logic         req_write = 1'b0;
  logic         req_user = 1'b0;
  logic         req_burst = 1'b0;
  logic         invalidate = 1'b0;
  logic         rsp_ready;
  logic [31:0]  rsp_data;
  logic         arr_rd;
  logic [18:0]  arr_addr;
  logic [255:0] arr_rdata = '0;

  int checks = 0, fails = 0, cyc = 0, ver = 0, arr_cnt = 0;
  string phase = "R11";

  flash_burst_buf uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_user(req_user), .req_burst(req_burst),
    .invalidate(invalidate), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .arr_rd(arr_rd), .arr_addr(arr_addr), .arr_rdata(arr_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] wfn(logic [18:0] line, int w, int v);
    return (32'(line) * 32'h01000193) ^ (32'(w) << 27) ^ (32'(v) * 32'h9E3779B1);
  endfunction

  function automatic logic [255:0] line_fn(logic [18:0] line, int v);
    logic [255:0] r;
    for (int w = 0; w < 8; w++) r[w*32 +: 32] = wfn(line, w, v);
    return r;
  endfunction

  always @(posedge clk) begin
    if (arr_rd) begin
      arr_rdata <= line_fn(arr_addr, ver);
      arr_cnt   <= arr_cnt + 1;
    end
  end

  // Behavioural reference model
  int          m_state = 0, m_way = 0, m_off = 0, m_lru = 0, m_pver = 0;
  bit          m_ready = 0, m_miss = 0;
  logic [31:0] m_data = '0;
  logic [18:0] m_cap = '0;
  logic [18:0] m_tag [2];
  bit          m_val [2];
  int          m_bver [2];

  function automatic bit m_accept();
    return req_valid && !req_write && (req_addr[23:18] == 6'h01) && !req_user;
  endfunction

  function automatic int m_hitway();
    for (int w = 0; w < 2; w++)
      if (m_val[w] && m_tag[w] == req_addr[23:5]) return w;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_ready = 0; m_lru = 0;
      m_val[0] = 0; m_val[1] = 0;
    end else begin
      case (m_state)
        0: if (m_accept()) begin
          int hw;
          hw = m_hitway();
          m_off = int'(req_addr[4:2]);
          m_cap = req_addr[23:5];
          m_miss = (hw < 0);
          if (hw >= 0) begin m_way = hw; m_lru = 1 - hw; end
          else begin m_way = m_lru; m_pver = ver; end
          m_state = 1;
        end
        1: begin
          if (m_miss) begin
            m_tag[m_way] = m_cap; m_bver[m_way] = m_pver;
            m_val[m_way] = 1; m_lru = 1 - m_way;
          end
          m_data = wfn(m_tag[m_way], m_off, m_bver[m_way]);
          m_ready = 1; m_state = 2;
        end
        default: begin
          if (req_valid && req_burst && m_off != 7) begin
            m_off++;
            m_data = wfn(m_tag[m_way], m_off, m_bver[m_way]);
          end else begin
            m_ready = 0; m_state = 0;
          end
        end
      endcase
      if (invalidate) begin m_val[0] = 0; m_val[1] = 0; end
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      bit exp_rd;
      exp_rd = (m_state == 0) && m_accept() && (m_hitway() < 0);
      chk(rsp_ready == m_ready, phase, "rsp_ready", rsp_ready, m_ready);
      if (m_ready) chk(rsp_data == m_data, phase, "rsp_data", rsp_data, m_data);
      chk(arr_rd == exp_rd, phase, "arr_rd", arr_rd, exp_rd);
      if (exp_rd) chk(arr_addr == req_addr[23:5], phase, "arr_addr", arr_addr, req_addr[23:5]);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic rd(input logic [23:0] a, input int nb, input bit wr, input bit usr,
                    input bit resp, output int got);
    got = 0;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = wr; req_user = usr; req_burst = (nb > 1);
    if (!resp) begin
      repeat (4) @(negedge clk);
      req_valid = 0; req_write = 0; req_user = 0; req_burst = 0;
      return;
    end
    do @(negedge clk); while (!rsp_ready);
    forever begin
      got++;
      if (got >= nb) req_burst = 0;
      if (got == 1) req_addr = 24'h04FFFF;  // junk address during the transfer, R12
      @(negedge clk);
      if (!rsp_ready) break;
    end
    req_valid = 0; req_burst = 0;
  endtask

  int got, c0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); #3;
    chk(rsp_ready == 1'b0, "R11", "reset ready", rsp_ready, 0);
    chk(arr_rd == 1'b0, "R11", "reset arr_rd", arr_rd, 0);

    phase = "R1";  rd(24'h040010, 1, 0, 0, 1, got);
    chk(got == 1, "R1", "single beats", got, 1);
    phase = "R5";  c0 = arr_cnt; rd(24'h040007, 1, 0, 0, 1, got);
    chk(arr_cnt == c0, "R6", "hit array reads", arr_cnt, c0);
    phase = "R2";  rd(24'h040008, 4, 0, 0, 1, got);
    chk(got == 4, "R2", "burst beats", got, 4);
    phase = "R3";  rd(24'h04000C, 2, 0, 0, 1, got);
    chk(got == 2, "R3", "bus-ended beats", got, 2);
    phase = "R4";  rd(24'h040016, 8, 0, 0, 1, got);
    chk(got == 3, "R4", "line end beats", got, 3);

    phase = "R7";  rd(24'h040104, 3, 0, 0, 1, got);
    c0 = arr_cnt;  rd(24'h040200, 1, 0, 0, 1, got);
    chk(arr_cnt == c0 + 1, "R7", "miss fetch", arr_cnt, c0 + 1);
    c0 = arr_cnt;  rd(24'h040108, 1, 0, 0, 1, got);
    chk(arr_cnt == c0, "R7", "survivor hit", arr_cnt, c0);
    c0 = arr_cnt;  rd(24'h040000, 1, 0, 0, 1, got);
    chk(arr_cnt == c0 + 1, "R7", "evicted line refetch", arr_cnt, c0 + 1);

    phase = "R9";  c0 = arr_cnt; rd(24'h040000, 1, 1, 0, 0, got);
    chk(rsp_ready == 0, "R9", "write no ready", rsp_ready, 0);
    rd(24'h040004, 1, 0, 0, 1, got);
    chk(arr_cnt == c0, "R9", "buffers kept after write", arr_cnt, c0);

    phase = "R10"; c0 = arr_cnt; rd(24'h000100, 1, 0, 0, 0, got);
    rd(24'h040100, 1, 0, 1, 0, got);
    chk(arr_cnt == c0, "R10", "ignored array reads", arr_cnt, c0);
    rd(24'h04010C, 1, 0, 0, 1, got);
    chk(arr_cnt == c0, "R10", "buffers kept", arr_cnt, c0);

    phase = "R8";
    @(negedge clk); invalidate = 1; ver++;
    @(negedge clk); invalidate = 0;
    c0 = arr_cnt; rd(24'h040100, 2, 0, 0, 1, got);
    chk(arr_cnt == c0 + 1, "R8", "miss after invalidate", arr_cnt, c0 + 1);
    fork
      rd(24'h040300, 1, 0, 0, 1, got);
      begin @(negedge clk); @(negedge clk); invalidate = 1; ver++; @(negedge clk); invalidate = 0; end
    join
    c0 = arr_cnt; rd(24'h040300, 1, 0, 0, 1, got);
    chk(arr_cnt == c0 + 1, "R8", "invalidate beats fill", arr_cnt, c0 + 1);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule